// File: doc/BRIEF.md
# Shared-Pin Memory Bus Cycle Sequencer

This block runs memory read and opcode-fetch cycles for an 8-bit processor with a 16-bit address space. The low address byte and the data byte travel over the same eight pins. The high address byte has its own pins. Every cycle walks through a fixed series of T-states. The first state puts the full address out and pulses a strobe so that an external transparent latch can hold the low byte. The following states release the shared pins and pull an active-low read strobe so that memory can drive the data back.

A client hands in one request at a time: a kind bit (fetch or plain read) and an address. A fetch takes its address from an internal program counter, which moves to the next byte once the fetch completes. A plain read uses the supplied address and takes one state fewer. The fetched or read byte comes back with a one-cycle completion pulse.

The request side is a valid/ready handshake. `req_ready` is high only while no cycle is in progress, and a request is taken on a clock edge where both valid and ready are high. The response side has no back-pressure. `rsp_valid` is a one-cycle pulse, and the client must take `rsp_data` in that cycle.

Top module: `adbus_cycle_ctrl`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `addr_stb`=0, `rd_n`=1, `mx_oe`=0, `rsp_valid`=0.
- R2: A request is taken on an edge with `req_valid`=1 and `req_ready`=1, and the very next cycle is state T1. While a cycle is in progress `req_ready` is 0, and a request presented then starts nothing.
- R3: In T1: `addr_stb`=1, `mx_oe`=1, `rd_n`=1, `mx_out` = address bits [7:0], `addr_hi` = address bits [15:8].
- R4: In T2 and T3: `addr_stb`=0, `mx_oe`=0, `rd_n`=0, and `addr_hi` still holds the cycle's high address byte.
- R5: The byte on `mx_in` is sampled on the clock edge that ends T3 and is returned on `rsp_data`.
- R6: A plain read (`req_fetch`=0) is T1..T3 only. `rsp_valid` is 1 in the cycle right after T3, and the read leaves the program counter unchanged.
- R7: A fetch (`req_fetch`=1) ignores `req_addr` and uses the program counter. It adds a fourth state T4 with `rd_n`=1, `mx_oe`=0 and `addr_stb`=0. `rsp_valid` is 1 in the cycle after T4, which is four bus states in all.
- R8: The program counter starts at parameter `RESET_PC` and increases by one at the end of each fetch, wrapping from 16'hFFFF to 16'h0000.
- R9: `rsp_valid` lasts exactly one cycle. In that same cycle `req_ready` is 1, so the next cycle can be taken with no idle gap.
- R10: `mx_oe` is never 1 while `rd_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_fetch | input | 1 | 1 = opcode fetch, 0 = plain read |
| req_addr | input | 16 | Address for a plain read |
| addr_hi | output | 8 | Upper address byte pins |
| mx_out | output | 8 | Shared pins, driven value |
| mx_oe | output | 1 | Shared pins output enable |
| mx_in | input | 8 | Shared pins, received value |
| addr_stb | output | 1 | High-active strobe for the external address latch |
| rd_n | output | 1 | Active-low read strobe |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Byte returned by the cycle |

## Verification
Two events can land in the same cycle: the completion pulse of one cycle and the acceptance of the next request. The program counter update at the end of a fetch also meets the address choice of a following fetch at that point. The bench raises `req_valid` in the cycle where `rsp_valid` is high. It then checks that T1 begins straight away and that a following fetch puts out the already-incremented counter. A request held high during T2 must leave no trace: `req_ready` stays 0 and the strobe stays low in the idle cycle after completion.

// File: rtl/adbus_pkg.sv
package adbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4
  } tstate_e;
endpackage

// File: rtl/adbus_pc.sv
module adbus_pc #(
  parameter int          AW       = 16,
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [AW-1:0] pc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= AW'(RESET_PC);
    else if (inc) pc <= pc + AW'(1);
  end

  // R8
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> pc == $past(pc) + AW'(1));
  // R8
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(pc));
endmodule

// File: rtl/adbus_seq.sv
module adbus_seq
  import adbus_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_fetch,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] pc,
  output logic          req_ready,
  output logic [AW-1:0] cyc_addr,
  output logic          addr_stb,
  output logic          rd_n,
  output logic          mx_oe,
  output logic          cap_en,
  output logic          done_en,
  output logic          pc_inc
);
  tstate_e state;
  logic    is_fetch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      is_fetch <= 1'b0;
      cyc_addr <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          state    <= ST_T1;
          is_fetch <= req_fetch;
          cyc_addr <= req_fetch ? pc : req_addr;
        end
        ST_T1:   state <= ST_T2;
        ST_T2:   state <= ST_T3;
        ST_T3:   state <= is_fetch ? ST_T4 : ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready = (state == ST_IDLE);
    addr_stb  = (state == ST_T1);
    mx_oe     = (state == ST_T1);
    rd_n      = !((state == ST_T2) || (state == ST_T3));
    cap_en    = (state == ST_T3);
    done_en   = ((state == ST_T3) && !is_fetch) || (state == ST_T4);
    pc_inc    = (state == ST_T4);
  end

  // R2
  accept_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> addr_stb);
  // R4
  stb_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb |=> (!addr_stb && !rd_n));
  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> $stable(cyc_addr));
endmodule

// File: rtl/adbus_capture.sv
module adbus_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic          done_en,
  input  logic [DW-1:0] mx_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= done_en;
      if (cap_en) rsp_data <= mx_in;
    end
  end

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R5
  rsp_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(cap_en)) |-> $stable(rsp_data));
endmodule

// File: rtl/adbus_cycle_ctrl.sv
module adbus_cycle_ctrl #(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_fetch,
  input  logic [AW-1:0]    req_addr,
  output logic [AW-DW-1:0] addr_hi,
  output logic [DW-1:0]    mx_out,
  output logic             mx_oe,
  input  logic [DW-1:0]    mx_in,
  output logic             addr_stb,
  output logic             rd_n,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data
);
  localparam int HW = AW - DW;

  logic [AW-1:0] pc;
  logic [AW-1:0] cyc_addr;
  logic          cap_en;
  logic          done_en;
  logic          pc_inc;

  adbus_pc #(.AW(AW), .RESET_PC(RESET_PC)) pc_i (
    .clk(clk), .rst_n(rst_n), .inc(pc_inc), .pc(pc)
  );

  adbus_seq #(.AW(AW)) seq_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fetch(req_fetch),
    .req_addr(req_addr), .pc(pc), .req_ready(req_ready), .cyc_addr(cyc_addr),
    .addr_stb(addr_stb), .rd_n(rd_n), .mx_oe(mx_oe), .cap_en(cap_en),
    .done_en(done_en), .pc_inc(pc_inc)
  );

  adbus_capture #(.DW(DW)) cap_i (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .done_en(done_en),
    .mx_in(mx_in), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  assign addr_hi = cyc_addr[AW-1:DW];
  assign mx_out  = cyc_addr[DW-1:0];

  // R10
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !mx_oe);
  // R3
  stb_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb |-> (mx_oe && rd_n));
  // R9
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  initial begin
    assert (HW > 0) else $error("address must be wider than data");
  end
endmodule

// File: tb/adbus_cycle_ctrl_tb_top.sv
module adbus_cycle_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_fetch = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_ready, mx_oe, addr_stb, rd_n, rsp_valid;
  logic [7:0]  addr_hi, mx_out, mx_in, rsp_data;
  logic [7:0]  lat_lo;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;
  logic [15:0] pc_model = 16'hFFFE;

  always #2 clk = ~clk;

  adbus_cycle_ctrl #(.RESET_PC(16'hFFFE)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_fetch(req_fetch), .req_addr(req_addr), .addr_hi(addr_hi),
    .mx_out(mx_out), .mx_oe(mx_oe), .mx_in(mx_in), .addr_stb(addr_stb),
    .rd_n(rd_n), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return (a[7:0] + 8'(a[15:8] * 3)) ^ 8'h3C;
  endfunction

  // external transparent address latch and memory model
  always_latch if (addr_stb) lat_lo = mx_out;
  assign mx_in = rd_n ? 8'hFF : mem_byte({addr_hi, lat_lo});

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one full bus cycle; entered and left at a negedge with the block idle
  task automatic run_cycle(input bit fetch, input logic [15:0] addr);
    logic [15:0] exp_a;
    exp_a = fetch ? pc_model : addr;
    req_valid = 1'b1; req_fetch = fetch;
    req_addr  = fetch ? 16'hDEAD : addr;
    chk(req_ready == 1'b1, "R2 ready before accept", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(addr_stb && mx_oe && rd_n, "R3 T1 strobes", {addr_stb, mx_oe, rd_n}, 3'b111);
    chk({addr_hi, mx_out} == exp_a, "R3 T1 address", {addr_hi, mx_out}, exp_a);
    chk(req_ready == 1'b0, "R2 busy in T1", 32'(req_ready), 0);
    @(negedge clk);
    chk(!addr_stb && !mx_oe && !rd_n, "R4 T2 strobes", {addr_stb, mx_oe, rd_n}, 3'b000);
    @(negedge clk);
    chk(!addr_stb && !mx_oe && !rd_n && addr_hi == exp_a[15:8], "R4 T3 strobes/hi",
        {addr_stb, mx_oe, rd_n, addr_hi}, {3'b000, exp_a[15:8]});
    chk(rsp_valid == 1'b0, "R6 no early done", 32'(rsp_valid), 0);
    if (fetch) begin
      @(negedge clk);
      chk(!addr_stb && !mx_oe && rd_n && !rsp_valid, "R7 T4 idle bus",
          {addr_stb, mx_oe, rd_n, rsp_valid}, 4'b0010);
      pc_model = pc_model + 16'd1;
    end
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R6 R7 done pulse", 32'(rsp_valid), 1);
    chk(rsp_data == mem_byte(exp_a), "R5 returned byte", rsp_data, mem_byte(exp_a));
    chk(req_ready == 1'b1, "R9 ready with done", 32'(req_ready), 1);
  endtask

  localparam logic [16:0] VEC [8] = '{
    {1'b1, 16'h0000}, {1'b0, 16'h1234}, {1'b1, 16'h0000}, {1'b0, 16'hABCD},
    {1'b1, 16'h0000}, {1'b1, 16'h0000}, {1'b0, 16'h00FF}, {1'b1, 16'h0000}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk(req_ready && !addr_stb && rd_n && !mx_oe && !rsp_valid, "R1 reset",
        {req_ready, addr_stb, rd_n, mx_oe, rsp_valid}, 5'b10100);
    rst_n = 1'b1;
    @(negedge clk);
    // vector walk, back to back: R8 wrap FFFE, FFFF, 0000 ... and R6 pc untouched by reads
    for (int i = 0; i < 8; i++) run_cycle(VEC[i][16], VEC[i][15:0]);
    // R9 single-cycle pulse
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 pulse width", 32'(rsp_valid), 0);
    // R2 request during busy is ignored
    req_valid = 1'b1; req_fetch = 1'b0; req_addr = 16'h4242;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h9999;
    chk(req_ready == 1'b0 && !rd_n, "R2 busy in T2", {req_ready, rd_n}, 2'b00);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_data == mem_byte(16'h4242), "R5 read data", rsp_data, mem_byte(16'h4242));
    @(negedge clk);
    chk(!addr_stb && req_ready, "R2 ignored request", {addr_stb, req_ready}, 2'b01);
    // R10 and R6: fetch after reads uses the tracked counter
    @(negedge clk);
    run_cycle(1'b1, 16'h0000);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule